// File: doc/BRIEF.md
# UART Interrupt Source Encoder with End-of-Data Detection

This block is the interrupt front end of a 16550-style UART whose receive path is drained by a DMA engine in 4-byte bursts. It collects six interrupt sources from the surrounding FIFOs and serial engines. Each source is gated by its own enable bit. The block reports the most urgent enabled source as a 3-bit identification code plus a "nothing pending" flag, and drives a single interrupt line.

Two sources suit DMA operation. The first is an end-of-data event, raised once after the receive line has been idle for a fixed number of character times following received traffic. The second is a receive timeout, which reports 1 to 3 leftover bytes that a 4-byte burst cannot collect. An idle counter measures the quiet time in character periods. It advances on an external character-time tick and restarts on every received character.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `iir` reads 4'b0001, `irq` is 0 and `ier_q` is 0.
- R2: `iir[0]` is 1 exactly when no enabled source is pending, and then `iir[3:1]` is 0. `irq` is the inverse of `iir[0]`. `iir[3:1]` codes are: 0 modem change, 1 transmit, 2 receive data, 3 line error, 4 end of data, 6 receive timeout. Codes 5 and 7 never appear.
- R3: A cycle with `ier_wr` high loads `ier_wdata` into `ier_q`. The enable bits are: bit0 receive data, bit1 transmit, bit2 line error, bit3 modem change, bit4 receive timeout, bit5 end of data. A pending source whose bit is 0 is not reported, and it is reported once its bit is set.
- R4: A 1 on any `err_in` bit (bit0 overrun, bit1 parity, bit2 framing, bit3 break) latches a line error. The line error is reported as `iir`=4'b0110 and is cleared by `lsr_rd`.
- R5: While `rx_level` is at least RX_TRIG (4), receive data is reported as `iir`=4'b0100.
- R6: Receive timeout (`iir`=4'b1100) is reported when `rx_level` is 1 to 3 and at least TO_CHARS (4) ticks have passed since the last received character.
- R7: End of data (`iir`=4'b1000) latches on the EOD_CHARS-th (4th) tick after a received character, only when bit5 is set, and only once per pause.
- R8: The end-of-data latch clears on `rx_char`, and on an IER write with bit5 at 0.
- R9: Transmit (`iir`=4'b0010) latches in two cases: when `tx_level` falls from above TX_LOW (16) to at or below it, or when an IER write sets bit1 from 0 while `tx_level` is at or below TX_LOW. It clears on `thr_wr`, or on `iir_rd` while `iir` reports transmit.
- R10: Priority from highest to lowest is line error, receive timeout, receive data, end of data, transmit, then modem change.
- R11: While `modem_delta` is 1, modem change is reported as `iir`=4'b0000.
- R12: Every `rx_char` restarts the idle count, including in a cycle that also carries `char_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 6 | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| err_in | input | 4 | Line error strobes: overrun, parity, framing, break |
| rx_char | input | 1 | A character was received |
| char_tick | input | 1 | One character time elapsed |
| modem_delta | input | 1 | Any modem status change pending |
| ier_q | output | 6 | Current enable register |
| iir | output | 4 | Identification: [3:1] source, [0] none pending |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks these properties on every cycle:
- the code space and the agreement between `irq` and the none-pending flag;
- that a line error is reported on the cycle after it arrives;
- that the clearing events (status read, holding-register write, received character, disabling end of data) remove their source one cycle later;
- that end of data is never shown while its enable bit is off.

Only the directed scenarios can show the following:
- idle-time counting in character periods, and the tick on which end of data and receive timeout appear;
- the once-per-pause rule and the restart of the count by a received character;
- the full priority chain as higher sources come and go.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int LVL_W     = 6,
  parameter int RX_TRIG   = 4,
  parameter int TX_LOW    = 16,
  parameter int BURST     = 4,
  parameter int EOD_CHARS = 4,
  parameter int TO_CHARS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [5:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             thr_wr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [3:0]       err_in,
  input  logic             rx_char,
  input  logic             char_tick,
  input  logic             modem_delta,
  output logic [5:0]       ier_q,
  output logic [3:0]       iir,
  output logic             irq
);
  localparam int IDLE_MAX = (EOD_CHARS > TO_CHARS) ? EOD_CHARS : TO_CHARS;
  localparam int CNT_W    = $clog2(IDLE_MAX + 1);
  localparam logic [2:0] ID_MS = 3'd0, ID_TX = 3'd1, ID_RXD = 3'd2,
                         ID_LS = 3'd3, ID_EOD = 3'd4, ID_RTO = 3'd6;

  logic [CNT_W-1:0] idle;
  logic armed, eod_pend, ls_pend, tx_pend, tx_low_q;
  logic [2:0] id;
  logic none;

  wire tx_low  = tx_level <= LVL_W'(TX_LOW);
  wire rxd_src = rx_level >= LVL_W'(RX_TRIG);
  wire rto_src = (rx_level != '0) && (rx_level < LVL_W'(BURST)) && (idle >= CNT_W'(TO_CHARS));
  wire eod_hit = char_tick && !rx_char && armed && (idle == CNT_W'(EOD_CHARS - 1));
  wire tx_set  = (tx_low && !tx_low_q) || (ier_wr && ier_wdata[1] && !ier_q[1] && tx_low);
  wire tx_clr  = thr_wr || (iir_rd && !none && id == ID_TX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idle <= '0;
    else if (rx_char) idle <= '0;
    else if (char_tick && idle != CNT_W'(IDLE_MAX)) idle <= idle + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else if (rx_char) armed <= 1'b1;
    else if (eod_hit) armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) eod_pend <= 1'b0;
    else if (rx_char || (ier_wr && !ier_wdata[5])) eod_pend <= 1'b0;
    else if (eod_hit && ier_q[5]) eod_pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ls_pend <= 1'b0;
    else if (|err_in) ls_pend <= 1'b1;
    else if (lsr_rd) ls_pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_low_q <= 1'b1;
      tx_pend  <= 1'b0;
    end else begin
      tx_low_q <= tx_low;
      if (tx_clr) tx_pend <= 1'b0;
      else if (tx_set) tx_pend <= 1'b1;
    end

  always_comb begin
    none = 1'b0;
    id   = ID_MS;
    if (ier_q[2] && ls_pend)          id = ID_LS;
    else if (ier_q[4] && rto_src)     id = ID_RTO;
    else if (ier_q[0] && rxd_src)     id = ID_RXD;
    else if (ier_q[5] && eod_pend)    id = ID_EOD;
    else if (ier_q[1] && tx_pend)     id = ID_TX;
    else if (ier_q[3] && modem_delta) id = ID_MS;
    else                              none = 1'b1;
  end

  assign iir = {none ? 3'b000 : id, none};
  assign irq = !none;
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [5:0] ier_wdata,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       rx_char,
  input logic [3:0] err_in,
  input logic [5:0] ier_q,
  input logic [3:0] iir,
  input logic       irq
);
  assert_code_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iir[3:1] != 3'd5 && iir[3:1] != 3'd7);
  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iir[0] |-> iir[3:1] == 3'd0);
  assert_irq_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);
  assert_eod_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:1] == 3'd4 && !iir[0]) |-> ier_q[5]);
  assert_err_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_in) && ier_q[2] && !(ier_wr && !ier_wdata[2])) |=> iir == 4'b0110);
  assert_lsr_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_in == 4'd0) |=> iir[3:1] != 3'd3);
  assert_char_clears_eod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char |=> iir[3:1] != 3'd4);
  assert_ier_clears_eod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !ier_wdata[5]) |=> iir[3:1] != 3'd4);
  assert_thr_clears_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !(iir[3:1] == 3'd1 && !iir[0]));
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .rx_char(rx_char), .err_in(err_in),
  .ier_q(ier_q), .iir(iir), .irq(irq)
);

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 0, iir_rd = 0, lsr_rd = 0, thr_wr = 0, rx_char = 0, char_tick = 0, modem_delta = 0;
  logic [5:0] ier_wdata = '0;
  logic [5:0] rx_level = '0, tx_level = 6'd20;
  logic [3:0] err_in = '0;
  logic [5:0] ier_q;
  logic [3:0] iir;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_id dut (.clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr), .rx_level(rx_level),
    .tx_level(tx_level), .err_in(err_in), .rx_char(rx_char), .char_tick(char_tick),
    .modem_delta(modem_delta), .ier_q(ier_q), .iir(iir), .irq(irq));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_iir(input logic [3:0] exp, input string tag);
    chk({4'd0, iir}, {4'd0, exp}, tag);
    chk({7'd0, irq}, {7'd0, !exp[0]}, {tag, " irq"});
  endtask

  task automatic wr_ier(input logic [5:0] v);
    ier_wdata = v; ier_wr = 1; @(negedge clk); ier_wr = 0;
  endtask
  task automatic pulse_char();  rx_char = 1;   @(negedge clk); rx_char = 0;   endtask
  task automatic pulse_tick();  char_tick = 1; @(negedge clk); char_tick = 0; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) pulse_tick(); endtask
  task automatic settle(); @(negedge clk); endtask

  task automatic t_reset();
    chk_iir(4'b0001, "R1 iir");
    chk({2'd0, ier_q}, 8'd0, "R1 ier");
  endtask

  task automatic t_ier();
    wr_ier(6'h2A); chk({2'd0, ier_q}, 8'h2A, "R3 ier load");
    wr_ier(6'h00); chk({2'd0, ier_q}, 8'h00, "R3 ier clear");
  endtask

  task automatic t_line();
    wr_ier(6'h04);
    err_in = 4'b0010; settle(); err_in = 0;
    chk_iir(4'b0110, "R4 parity");
    lsr_rd = 1; settle(); lsr_rd = 0;
    chk_iir(4'b0001, "R4 lsr clear");
    wr_ier(6'h00);
    err_in = 4'b1000; settle(); err_in = 0;
    chk_iir(4'b0001, "R3 masked break");
    wr_ier(6'h04);
    chk_iir(4'b0110, "R3 unmask");
    lsr_rd = 1; settle(); lsr_rd = 0;
    wr_ier(6'h00);
  endtask

  task automatic t_rxdata();
    wr_ier(6'h01);
    rx_level = 6'd3; settle(); chk_iir(4'b0001, "R5 below trig");
    rx_level = 6'd4; settle(); chk_iir(4'b0100, "R5 at trig");
    rx_level = 6'd0; wr_ier(6'h00);
  endtask

  task automatic t_eod();
    wr_ier(6'h30);
    rx_level = 6'd2; pulse_char();
    ticks(3); chk_iir(4'b0001, "R7 early");
    pulse_tick(); chk_iir(4'b1100, "R6 R10 rto first");
    rx_level = 6'd0; settle(); chk_iir(4'b1000, "R7 eod");
    ticks(2); chk_iir(4'b1000, "R7 eod held");
    pulse_char(); chk_iir(4'b0001, "R8 char clears");
    ticks(4); chk_iir(4'b1000, "R7 second pause");
    wr_ier(6'h10); chk_iir(4'b0001, "R8 ier clears");
    wr_ier(6'h30); ticks(4); chk_iir(4'b0001, "R7 once per pause");
    pulse_char(); ticks(2); pulse_char(); ticks(3);
    chk_iir(4'b0001, "R12 restart");
    pulse_tick(); chk_iir(4'b1000, "R12 after restart");
    rx_char = 1; char_tick = 1; settle(); rx_char = 0; char_tick = 0;
    ticks(3); chk_iir(4'b0001, "R12 char beats tick");
    pulse_tick(); chk_iir(4'b1000, "R12 fourth tick");
    wr_ier(6'h00);
  endtask

  task automatic t_tx();
    wr_ier(6'h02);
    tx_level = 6'd10; settle(); chk_iir(4'b0010, "R9 fall");
    thr_wr = 1; settle(); thr_wr = 0; chk_iir(4'b0001, "R9 thr clear");
    tx_level = 6'd20; settle(); tx_level = 6'd16; settle();
    chk_iir(4'b0010, "R9 fall to limit");
    iir_rd = 1; settle(); iir_rd = 0; chk_iir(4'b0001, "R9 iir read clear");
    wr_ier(6'h00); wr_ier(6'h02); chk_iir(4'b0010, "R9 enable while low");
    thr_wr = 1; settle(); thr_wr = 0; tx_level = 6'd20; settle();
    wr_ier(6'h00);
  endtask

  task automatic t_modem();
    wr_ier(6'h08);
    modem_delta = 1; settle(); chk_iir(4'b0000, "R11 modem");
    modem_delta = 0; settle(); chk_iir(4'b0001, "R11 modem gone");
    wr_ier(6'h00);
  endtask

  task automatic t_prio();
    wr_ier(6'h3F);
    modem_delta = 1; settle(); chk_iir(4'b0000, "R10 ms");
    tx_level = 6'd10; settle(); chk_iir(4'b0010, "R10 tx over ms");
    rx_level = 6'd2; pulse_char(); ticks(3); chk_iir(4'b0010, "R10 tx idle");
    pulse_tick(); chk_iir(4'b1100, "R10 rto over all");
    rx_level = 6'd0; settle(); chk_iir(4'b1000, "R10 eod over tx");
    rx_level = 6'd5; settle(); chk_iir(4'b0100, "R10 rxd over eod");
    err_in = 4'b0001; settle(); err_in = 0; chk_iir(4'b0110, "R10 ls top");
    lsr_rd = 1; settle(); lsr_rd = 0; chk_iir(4'b0100, "R10 back to rxd");
    rx_level = 6'd0; settle(); chk_iir(4'b1000, "R10 back to eod");
    pulse_char(); chk_iir(4'b0010, "R10 back to tx");
    thr_wr = 1; settle(); thr_wr = 0; chk_iir(4'b0000, "R10 back to ms");
    modem_delta = 0; settle(); chk_iir(4'b0001, "R2 none");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; settle();
    t_reset();
    t_ier();
    t_line();
    t_rxdata();
    t_eod();
    t_tx();
    t_modem();
    t_prio();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule